// File: doc/BRIEF.md
# Dual-Processor Interrupt Level Encoder

This block serves two processors that share most of their interrupt sources. Each processor has five request sources. In rising priority they are PWM, command, horizontal, vertical and reset. Any source can be pending in a shared register that both processors see, or in a private register that belongs to one processor. The block combines the shared and private registers for each processor and filters the result through that processor's 4-bit enable mask. It then presents one encoded priority level per processor.

The block also carries one on-chip peripheral request per processor, with its own level and vector number. When a processor acknowledges, the block compares the external level with the peripheral request and answers with a vector number. If the peripheral request is the one served, it drops by itself, and the served external level is recorded as that processor's current level.

Top module: `dual_irq_level`

## Requirements
- R1: After reset, both levels, both current levels, both acknowledge vectors, both acknowledge-valid flags, both peripheral-pending flags and both masks are zero.
- R2: A pending bit, shared or private, is set by a one-cycle set strobe and cleared by a write-one-to-clear strobe. When set and clear hit the same bit in the same cycle, the set wins. Bit order in every source vector is: bit 0 PWM, bit 1 command, bit 2 horizontal, bit 3 vertical, bit 4 reset.
- R3: Each processor's active set is the OR of the shared and its own private pending bits. Source bits 0..3 each pass only when mask bit 0..3 of that processor is 1.
- R4: Source bit 4 (reset) ignores the mask. A set strobe on shared bit 4 drives both processors' levels to 14 on the second clock edge after the strobe.
- R5: The level is 2*(3+i), where i is the highest active source bit. This gives 6, 8, 10, 12 and 14 for bits 0..4. The level is 0 when no bit is active, and it is always even.
- R6: Levels are registered. A pending or mask change made at one edge shows in the level only at the following edge.
- R7: On an acknowledge, if the processor's level is strictly greater than its peripheral request level, the vector is 64 + level/2. The peripheral request is then left untouched.
- R8: Otherwise the vector is the peripheral vector input, the peripheral request is cleared, and the current level output takes the level that was presented at the acknowledge.
- R9: A peripheral request that is not pending counts as level 0, whatever its level input holds.
- R10: A peripheral set strobe in the same cycle as an acknowledge that would clear the request leaves the request pending.
- R11: The two processors' acknowledges are independent. Both may fire in the same cycle, and each is decided from its own level and its own peripheral request.
- R12: The acknowledge vector and a one-cycle acknowledge-valid flag appear one edge after the acknowledge strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sharedSet | input | 5 | Set strobes for shared pending bits |
| sharedClr | input | 5 | Write-one-to-clear strobes for shared pending bits |
| privSet | input | 2x5 | Set strobes for private pending bits, per processor |
| privClr | input | 2x5 | Clear strobes for private pending bits, per processor |
| maskWe | input | 2 | Mask write enable, per processor |
| maskWdata | input | 2x4 | Mask write data, per processor |
| perSet | input | 2 | Peripheral request set strobe, per processor |
| perLevel | input | 2x4 | Peripheral request level, per processor |
| perVector | input | 2x8 | Peripheral vector number, per processor |
| ackStb | input | 2 | Acknowledge strobe, per processor |
| irqLevel | output | 2x4 | Encoded priority level, per processor |
| curLevel | output | 2x4 | Level recorded when a peripheral acknowledge is served |
| perPending | output | 2 | Peripheral request pending, per processor |
| ackVector | output | 2x8 | Vector returned by the last acknowledge |
| ackValid | output | 2 | Vector valid, one cycle after an acknowledge |

## Verification
An acknowledge that clears a peripheral request can land in the same cycle as a new peripheral set strobe, and both acknowledges can fire together. The bench raises a peripheral request whose level beats the external level, then pulses acknowledge and set together. It expects the peripheral vector back and the request still pending. A second case acknowledges both processors in one cycle, one won by the external level and one by the peripheral. The bench checks each vector, pending flag and current level against values it computes from that processor's own state. The level encoder is swept over every mask and every source pattern, with the sources split between shared and private registers.

// File: rtl/irqlvl_pkg.sv
package irqlvl_pkg;
  localparam int NCPU = 2;

  typedef struct packed {
    logic [NCPU-1:0] take;     // acknowledge accepted this cycle
    logic [NCPU-1:0] pickExt;  // external level wins the arbitration
    logic [NCPU-1:0] dropPer;  // peripheral request is served and cleared
  } ackCtl_t;
endpackage

// File: rtl/irqlvl_ctrl.sv
module irqlvl_ctrl
  import irqlvl_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic [NCPU-1:0]            ackStb,
  input  logic [NCPU-1:0][LVL_W-1:0] irqLevel,
  input  logic [NCPU-1:0]            perPending,
  input  logic [NCPU-1:0][LVL_W-1:0] perLevel,
  output ackCtl_t                    ctl
);
  logic [NCPU-1:0][LVL_W-1:0] perEff;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    // an idle peripheral request competes with level zero
    assign perEff[c]         = perPending[c] ? perLevel[c] : '0;
    assign ctl.take[c]       = ackStb[c];
    assign ctl.pickExt[c]    = irqLevel[c] > perEff[c];
    assign ctl.dropPer[c]    = ackStb[c] && !(irqLevel[c] > perEff[c]);
  end
endmodule

// File: rtl/irqlvl_datapath.sv
module irqlvl_datapath
  import irqlvl_pkg::*;
#(
  parameter int MASK_W       = 4,
  parameter int SRC_BASE     = 3,
  parameter int LVL_W        = 4,
  parameter int VEC_W        = 8,
  parameter int EXT_VEC_BASE = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [MASK_W:0]             sharedSet,
  input  logic [MASK_W:0]             sharedClr,
  input  logic [NCPU-1:0][MASK_W:0]   privSet,
  input  logic [NCPU-1:0][MASK_W:0]   privClr,
  input  logic [NCPU-1:0]             maskWe,
  input  logic [NCPU-1:0][MASK_W-1:0] maskWdata,
  input  logic [NCPU-1:0]             perSet,
  input  logic [NCPU-1:0][VEC_W-1:0]  perVector,
  input  ackCtl_t                     ctl,
  output logic [NCPU-1:0][LVL_W-1:0]  irqLevel,
  output logic [NCPU-1:0][LVL_W-1:0]  curLevel,
  output logic [NCPU-1:0]             perPending,
  output logic [NCPU-1:0][VEC_W-1:0]  ackVector,
  output logic [NCPU-1:0]             ackValid
);
  localparam int SRC_W = MASK_W + 1;

  logic [SRC_W-1:0]             sharedPend;
  logic [NCPU-1:0][SRC_W-1:0]   privPend;
  logic [NCPU-1:0][MASK_W-1:0]  maskReg;
  logic [NCPU-1:0][SRC_W-1:0]   active;
  logic [NCPU-1:0][LVL_W-1:0]   lvlNext;
  logic [NCPU-1:0][VEC_W-1:0]   extVec;

  // shared pending: set strobe dominates a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rstN) sharedPend <= '0;
    else       sharedPend <= (sharedPend & ~sharedClr) | sharedSet;
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (!rstN) begin
        privPend[c] <= '0;
        maskReg[c]  <= '0;
      end else begin
        privPend[c] <= (privPend[c] & ~privClr[c]) | privSet[c];
        if (maskWe[c]) maskReg[c] <= maskWdata[c];
      end
    end

    // top source (reset) always passes; the rest are gated by the mask
    assign active[c] = (sharedPend | privPend[c]) & {1'b1, maskReg[c]};

    always_comb begin
      lvlNext[c] = '0;
      for (int i = 0; i < SRC_W; i++) begin
        if (active[c][i]) lvlNext[c] = LVL_W'(2 * (SRC_BASE + i));
      end
    end

    assign extVec[c] = VEC_W'(EXT_VEC_BASE) + VEC_W'(irqLevel[c] >> 1);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        irqLevel[c]   <= '0;
        curLevel[c]   <= '0;
        perPending[c] <= 1'b0;
        ackVector[c]  <= '0;
        ackValid[c]   <= 1'b0;
      end else begin
        irqLevel[c]   <= lvlNext[c];
        perPending[c] <= perSet[c] | (perPending[c] & ~ctl.dropPer[c]);
        ackValid[c]   <= ctl.take[c];
        if (ctl.take[c])
          ackVector[c] <= ctl.pickExt[c] ? extVec[c] : perVector[c];
        if (ctl.dropPer[c])
          curLevel[c] <= irqLevel[c];
      end
    end
  end
endmodule

// File: rtl/dual_irq_level.sv
module dual_irq_level
  import irqlvl_pkg::*;
#(
  parameter int MASK_W       = 4,
  parameter int SRC_BASE     = 3,
  parameter int LVL_W        = 4,
  parameter int VEC_W        = 8,
  parameter int EXT_VEC_BASE = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [MASK_W:0]             sharedSet,
  input  logic [MASK_W:0]             sharedClr,
  input  logic [NCPU-1:0][MASK_W:0]   privSet,
  input  logic [NCPU-1:0][MASK_W:0]   privClr,
  input  logic [NCPU-1:0]             maskWe,
  input  logic [NCPU-1:0][MASK_W-1:0] maskWdata,
  input  logic [NCPU-1:0]             perSet,
  input  logic [NCPU-1:0][LVL_W-1:0]  perLevel,
  input  logic [NCPU-1:0][VEC_W-1:0]  perVector,
  input  logic [NCPU-1:0]             ackStb,
  output logic [NCPU-1:0][LVL_W-1:0]  irqLevel,
  output logic [NCPU-1:0][LVL_W-1:0]  curLevel,
  output logic [NCPU-1:0]             perPending,
  output logic [NCPU-1:0][VEC_W-1:0]  ackVector,
  output logic [NCPU-1:0]             ackValid
);
  ackCtl_t ctl;

  irqlvl_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .ackStb     (ackStb),
    .irqLevel   (irqLevel),
    .perPending (perPending),
    .perLevel   (perLevel),
    .ctl        (ctl)
  );

  irqlvl_datapath #(
    .MASK_W(MASK_W), .SRC_BASE(SRC_BASE), .LVL_W(LVL_W),
    .VEC_W(VEC_W), .EXT_VEC_BASE(EXT_VEC_BASE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sharedSet  (sharedSet),
    .sharedClr  (sharedClr),
    .privSet    (privSet),
    .privClr    (privClr),
    .maskWe     (maskWe),
    .maskWdata  (maskWdata),
    .perSet     (perSet),
    .perVector  (perVector),
    .ctl        (ctl),
    .irqLevel   (irqLevel),
    .curLevel   (curLevel),
    .perPending (perPending),
    .ackVector  (ackVector),
    .ackValid   (ackValid)
  );
endmodule

// File: rtl/dual_irq_level_checker.sv
module dual_irq_level_checker
  import irqlvl_pkg::*;
#(
  parameter int MASK_W   = 4,
  parameter int SRC_BASE = 3,
  parameter int LVL_W    = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [MASK_W:0]            sharedSet,
  input logic [NCPU-1:0]            perSet,
  input logic [NCPU-1:0]            ackStb,
  input logic [NCPU-1:0][LVL_W-1:0] irqLevel,
  input logic [NCPU-1:0][LVL_W-1:0] perLevel,
  input logic [NCPU-1:0]            perPending,
  input logic [NCPU-1:0]            ackValid,
  input logic [NCPU-1:0][LVL_W-1:0] curLevel
);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(2 * (SRC_BASE + MASK_W));

  // R4: the reset source reaches both processors together, mask or not
  p_rst_both_r4: assert property (@(posedge clk) disable iff (!rstN)
    sharedSet[MASK_W] |=> ##1 (irqLevel[0] == TOP_LVL && irqLevel[1] == TOP_LVL));

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    // R5: encoded levels are even
    p_level_even_r5: assert property (@(posedge clk) disable iff (!rstN)
      irqLevel[c][0] == 1'b0);

    // R12: valid follows the strobe by one edge, and only then
    p_ack_valid_r12: assert property (@(posedge clk) disable iff (!rstN)
      ackStb[c] |=> ackValid[c]);
    p_no_stray_valid_r12: assert property (@(posedge clk) disable iff (!rstN)
      !ackStb[c] |=> !ackValid[c]);

    // R7: an external win leaves the peripheral request as it was
    p_ext_keeps_r7: assert property (@(posedge clk) disable iff (!rstN)
      (ackStb[c] && perPending[c] && !perSet[c] && irqLevel[c] > perLevel[c])
      |=> perPending[c]);

    // R8: a peripheral win clears the request
    p_auto_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
      (ackStb[c] && perPending[c] && !perSet[c] && !(irqLevel[c] > perLevel[c]))
      |=> !perPending[c]);

    // R8: the recorded level is the level seen at the serving acknowledge
    p_cur_level_r8: assert property (@(posedge clk) disable iff (!rstN)
      $fell(perPending[c]) |-> curLevel[c] == $past(irqLevel[c]));

    // R10: a new request survives a same-cycle clearing acknowledge
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
      perSet[c] |=> perPending[c]);
  end
endmodule

bind dual_irq_level dual_irq_level_checker #(
  .MASK_W(MASK_W), .SRC_BASE(SRC_BASE), .LVL_W(LVL_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sharedSet  (sharedSet),
  .perSet     (perSet),
  .ackStb     (ackStb),
  .irqLevel   (irqLevel),
  .perLevel   (perLevel),
  .perPending (perPending),
  .ackValid   (ackValid),
  .curLevel   (curLevel)
);

// File: tb/test_dual_irq_level.sv
module test_dual_irq_level;
  logic            clk = 1'b0;
  logic            rstN;
  logic [4:0]      sharedSet, sharedClr;
  logic [1:0][4:0] privSet, privClr;
  logic [1:0]      maskWe;
  logic [1:0][3:0] maskWdata;
  logic [1:0]      perSet;
  logic [1:0][3:0] perLevel;
  logic [1:0][7:0] perVector;
  logic [1:0]      ackStb;
  logic [1:0][3:0] irqLevel, curLevel;
  logic [1:0]      perPending;
  logic [1:0][7:0] ackVector;
  logic [1:0]      ackValid;

  int nChk = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  dual_irq_level i_dual_irq_level (
    .clk(clk), .rstN(rstN),
    .sharedSet(sharedSet), .sharedClr(sharedClr),
    .privSet(privSet), .privClr(privClr),
    .maskWe(maskWe), .maskWdata(maskWdata),
    .perSet(perSet), .perLevel(perLevel), .perVector(perVector),
    .ackStb(ackStb),
    .irqLevel(irqLevel), .curLevel(curLevel), .perPending(perPending),
    .ackVector(ackVector), .ackValid(ackValid)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expLevel(input logic [4:0] act, input logic [3:0] m);
    logic [4:0] a = act & {1'b1, m};
    for (int i = 4; i >= 0; i--) if (a[i]) return 2 * (3 + i);
    return 0;
  endfunction

  task automatic idle();
    sharedSet = '0; sharedClr = '0; privSet = '0; privClr = '0;
    maskWe = '0; perSet = '0; ackStb = '0;
  endtask

  // clear everything, load new pending bits and masks, wait for the level
  task automatic load(input logic [4:0] s, input logic [4:0] p0, input logic [4:0] p1,
                      input logic [3:0] m0, input logic [3:0] m1, input bit checkLag);
    sharedClr = '1; privClr = '1;
    @(negedge clk);
    idle();
    sharedSet = s; privSet[0] = p0; privSet[1] = p1;
    maskWe = 2'b11; maskWdata[0] = m0; maskWdata[1] = m1;
    @(negedge clk);
    idle();
    if (checkLag) begin
      chk("R6 lag cpu0", irqLevel[0], 0);
      chk("R6 lag cpu1", irqLevel[1], 0);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    idle();
    maskWdata = '0; perLevel = '0;
    perVector[0] = 8'hA5; perVector[1] = 8'h3C;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int c = 0; c < 2; c++) begin
      chk("R1 level", irqLevel[c], 0);
      chk("R1 curLevel", curLevel[c], 0);
      chk("R1 perPending", perPending[c], 0);
      chk("R1 ackVector", ackVector[c], 0);
      chk("R1 ackValid", ackValid[c], 0);
    end
    // R1: masks at zero let only the reset source through
    privSet[0] = 5'b01111; privSet[1] = 5'b01111;
    @(negedge clk); idle(); @(negedge clk);
    chk("R1 mask zero cpu0", irqLevel[0], 0);
    chk("R1 mask zero cpu1", irqLevel[1], 0);

    // R3 R4 R5 R6: sweep every mask and source pattern
    for (int m = 0; m < 16; m++) begin
      for (int pat = 0; pat < 32; pat++) begin
        logic [4:0] s, p0, p1;
        s  = 5'(pat) & 5'b10100;
        p0 = 5'(pat) & 5'b01011;
        p1 = ~5'(pat) & 5'b01011;
        load(s, p0, p1, 4'(m), ~4'(m), (pat == 31));
        chk("R3 R5 cpu0 level", irqLevel[0], expLevel(s | p0, 4'(m)));
        chk("R3 R5 cpu1 level", irqLevel[1], expLevel(s | p1, ~4'(m)));
        if (s[4]) chk("R4 both reset", {28'd0, irqLevel[0]} + {28'd0, irqLevel[1]}, 28);
      end
    end

    // R2: set and clear in one cycle, set wins; then clear alone
    load(5'b00000, 5'b0, 5'b0, 4'hF, 4'hF, 1'b0);
    sharedSet = 5'b01000; sharedClr = 5'b01000;
    @(negedge clk); idle(); @(negedge clk);
    chk("R2 set wins", irqLevel[0], 12);
    sharedClr = 5'b01000;
    @(negedge clk); idle(); @(negedge clk);
    chk("R2 w1c clear", irqLevel[0], 0);
    privSet[1] = 5'b00100; privClr[1] = 5'b00100;
    @(negedge clk); idle(); @(negedge clk);
    chk("R2 private set wins", irqLevel[1], 10);

    // R7: external 12 beats peripheral 5
    load(5'b0, 5'b01000, 5'b0, 4'hF, 4'hF, 1'b0);
    perLevel[0] = 4'd5; perSet[0] = 1'b1;
    @(negedge clk); idle();
    ackStb[0] = 1'b1;
    @(negedge clk); idle();
    chk("R7 ext vector", ackVector[0], 70);
    chk("R7 pending kept", perPending[0], 1);
    chk("R12 valid", ackValid[0], 1);
    @(negedge clk);
    chk("R12 valid drops", ackValid[0], 0);

    // R8: equal levels go to the peripheral
    perLevel[0] = 4'd12; ackStb[0] = 1'b1;
    @(negedge clk); idle();
    chk("R8 per vector", ackVector[0], 8'hA5);
    chk("R8 auto clear", perPending[0], 0);
    chk("R8 curLevel", curLevel[0], 12);

    // R9: idle peripheral with high level input does not compete
    perLevel[0] = 4'd15; ackStb[0] = 1'b1;
    @(negedge clk); idle();
    chk("R9 ext vs idle", ackVector[0], 70);
    load(5'b0, 5'b0, 5'b0, 4'hF, 4'hF, 1'b0);
    ackStb[0] = 1'b1;
    @(negedge clk); idle();
    chk("R9 zero level", ackVector[0], 8'hA5);
    chk("R9 curLevel", curLevel[0], 0);

    // R10: set and serving acknowledge in one cycle
    load(5'b0, 5'b01000, 5'b0, 4'hF, 4'hF, 1'b0);
    perLevel[0] = 4'd15; perSet[0] = 1'b1;
    @(negedge clk); idle();
    perSet[0] = 1'b1; ackStb[0] = 1'b1;
    @(negedge clk); idle();
    chk("R10 vector", ackVector[0], 8'hA5);
    chk("R10 still pending", perPending[0], 1);
    chk("R10 curLevel", curLevel[0], 12);

    // R11: both acknowledges in one cycle, opposite winners
    load(5'b01000, 5'b0, 5'b0, 4'hF, 4'hF, 1'b0);
    perLevel[1] = 4'd3; perSet[1] = 1'b1;
    @(negedge clk); idle();
    ackStb = 2'b11;
    @(negedge clk); idle();
    chk("R11 cpu0 vector", ackVector[0], 8'hA5);
    chk("R11 cpu0 cleared", perPending[0], 0);
    chk("R11 cpu1 vector", ackVector[1], 70);
    chk("R11 cpu1 kept", perPending[1], 1);
    chk("R11 both valid", ackValid, 3);
    chk("R11 cpu1 curLevel", curLevel[1], 0);

    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule